// File: doc/BRIEF.md
# Triple-Redundant Position Voter with Repair Control

This block sits behind three identical copies of a stateful game engine. The three copies run on identical inputs. Each copy reports four position words: the ball's horizontal and vertical coordinates, the player's paddle height and the computer's paddle height. Every cycle the block takes all three reports and forms a bit-wise two-out-of-three result. It registers that result as the single output seen by the rest of the system. It also works out which copy, if any, is out of step with the other two.

When exactly one copy disagrees, the block names that copy and asks for it to be rebuilt while the other two keep running. Once the rebuild is acknowledged, the block offers the current voted words over a valid/ready handshake, so that the rebuilt copy can load the state it lost when it restarted from reset. When two or more copies disagree, the block raises a sticky uncorrectable flag and starts no repair. A host can deliberately corrupt one word of one copy's report, to emulate a radiation upset and show that the fault is masked.

Top module: `tmr_voter_top`

## Requirements
- R1: `voted_data` is the bit-wise majority of the three replica words, after any injection, sampled at a rising clock edge. It appears one cycle later.
- R2: When only one replica carries wrong bits, of any pattern, `voted_data` equals the value shared by the other two.
- R3: `mismatch[k]` goes high in the cycle after replica k (after injection) differs from the majority in any bit. It stays high until a cycle with `flag_clear` high, and that clear is overridden only by a fresh disagreement.
- R4: A cycle with `inj_load` high stores the injection setting. `inj_sel` 0 means none and 1, 2, 3 select replicas 0, 1, 2. Field i lies in bits [10*i+9 : 10*i]: field 0 is ball X, 1 is ball Y, 2 is the player paddle and 3 is the computer paddle. From the next edge on, `inj_mask` is XORed into that field of the selected replica before voting.
- R5: When the controller is idle and exactly one replica disagrees, `repair_req` shows that replica one-hot in the next cycle. It holds until `repair_done` is seen high.
- R6: After `repair_done`, `sync_valid` is high with `sync_tgt` naming the same replica and `voted_data` as payload. Both hold until `sync_ready` is high, and then the controller returns to idle.
- R7: Starting a repair of replica k removes any injection aimed at replica k, so no further disagreement comes from it.
- R8: When two or three replicas disagree with the majority, `uncorrectable` goes high in the next cycle with no repair request. It stays high until `flag_clear`.
- R9: While a replica is under repair or resync, its disagreement is ignored: it sets no mismatch bit, raises no uncorrectable flag and starts no repair.
- R10: During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rep0_data | input | 40 | Replica 0 position words, four 10-bit fields |
| rep1_data | input | 40 | Replica 1 position words |
| rep2_data | input | 40 | Replica 2 position words |
| inj_load | input | 1 | Store a new injection setting |
| inj_sel | input | 2 | Injection target: 0 none, 1..3 replica 0..2 |
| inj_field | input | 2 | Field index to corrupt |
| inj_mask | input | 10 | XOR mask applied to that field |
| flag_clear | input | 1 | Clear the sticky mismatch and uncorrectable flags |
| voted_data | output | 40 | Registered majority result, also the resync payload |
| mismatch | output | 3 | Sticky per-replica disagreement flags |
| uncorrectable | output | 1 | Sticky multi-replica disagreement flag |
| repair_req | output | 3 | One-hot repair request |
| repair_done | input | 1 | Repair of the requested replica finished |
| sync_valid | output | 1 | Voted state offered to the rebuilt replica |
| sync_ready | input | 1 | Rebuilt replica has taken the state |
| sync_tgt | output | 3 | One-hot replica being resynchronised |

## Verification
Some properties are checked on every cycle by assertions. These are: the one-hot shape of the repair request and that it holds until acknowledged; that the resync offer stays stable until it is accepted; that no mismatch flag falls without a clear; that an uncorrectable event never starts a repair; that the injection setting changes only on a load or a clear; and that starting a repair removes any injection aimed at that replica. Other behaviour can only be shown by the bench's scenarios. These are: the masking of random single-replica corruption, the exact bit positions of injected fields, ignoring a replica under repair while another goes bad, and the flag clearing behaviour.

// File: rtl/tmr_vote_pkg.sv
// Shared definitions for the triple-redundant voter.
// Assumes exactly three replicas; replica indices are 0..2.
package tmr_vote_pkg;
    localparam int NUM_REPL = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPAIR = 2'd1,
        ST_SYNC   = 2'd2
    } rep_state_e;
endpackage

// File: rtl/tmr_fault_inject.sv
// Holds the host's fault-injection setting and XORs its mask into one
// field of one replica's report before voting.
// Assumes select code 0 means "no injection" and codes 1..3 map to replicas 0..2.
module tmr_fault_inject #(
    parameter int FIELD_W    = 10,
    parameter int NUM_FIELDS = 4,
    parameter int DATA_W     = FIELD_W * NUM_FIELDS,
    parameter int IDX_W      = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [1:0]             sel_i,
    input  logic [IDX_W-1:0]       field_i,
    input  logic [FIELD_W-1:0]     mask_i,
    input  logic                   clear_i,
    input  logic [1:0]             clear_idx_i,
    input  logic [2:0][DATA_W-1:0] raw_i,
    output logic [2:0][DATA_W-1:0] eff_o,
    output logic [1:0]             tgt_o
);
    logic [1:0]         sel_q;
    logic [1:0]         sel_next;
    logic [IDX_W-1:0]   field_q;
    logic [FIELD_W-1:0] mask_q;

    // Select for the next cycle: a load replaces it, a matching repair start removes it.
    always_comb begin
        sel_next = load_i ? sel_i : sel_q;
        if (clear_i && (sel_next == clear_idx_i + 2'd1)) begin
            sel_next = 2'd0;
        end
    end

    // Injection setting register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 2'd0;
            field_q <= '0;
            mask_q  <= '0;
        end else begin
            sel_q <= sel_next;
            if (load_i) begin
                field_q <= field_i;
                mask_q  <= mask_i;
            end
        end
    end

    // Apply the mask to the chosen replica's chosen field.
    for (genvar r = 0; r < 3; r++) begin : g_repl
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            logic hit;
            assign hit = (sel_q == 2'(r + 1)) && (field_q == IDX_W'(f));
            assign eff_o[r][f*FIELD_W +: FIELD_W] =
                raw_i[r][f*FIELD_W +: FIELD_W] ^ (hit ? mask_q : '0);
        end
    end

    assign tgt_o = sel_q;

    // R4
    inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> $stable(tgt_o));
endmodule

// File: rtl/tmr_majority.sv
// Bit-wise two-out-of-three vote over all fields, plus a per-replica
// flag telling whether that replica differs from the result anywhere.
// Purely combinational; the caller registers the result.
module tmr_majority #(
    parameter int FIELD_W    = 10,
    parameter int NUM_FIELDS = 4,
    parameter int DATA_W     = FIELD_W * NUM_FIELDS
) (
    input  logic [2:0][DATA_W-1:0] rep_i,
    output logic [DATA_W-1:0]      maj_o,
    output logic [2:0]             diff_o
);
    logic [2:0][NUM_FIELDS-1:0] fdiff;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] a, b, c, m;
        assign a = rep_i[0][f*FIELD_W +: FIELD_W];
        assign b = rep_i[1][f*FIELD_W +: FIELD_W];
        assign c = rep_i[2][f*FIELD_W +: FIELD_W];
        assign m = (a & b) | (a & c) | (b & c);
        assign maj_o[f*FIELD_W +: FIELD_W] = m;
        assign fdiff[0][f] = |(a ^ m);
        assign fdiff[1][f] = |(b ^ m);
        assign fdiff[2][f] = |(c ^ m);
    end

    for (genvar r = 0; r < 3; r++) begin : g_red
        assign diff_o[r] = |fdiff[r];
    end
endmodule

// File: rtl/tmr_repair_ctrl.sv
// Classifies disagreements, keeps the sticky flags and runs the
// repair-request then resync handshake for one faulty replica at a time.
// Assumes diff_i is taken from the same cycle's vote; the replica under
// repair is masked out of classification until it is resynchronised.
module tmr_repair_ctrl
    import tmr_vote_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] diff_i,
    input  logic       clear_i,
    input  logic       repair_done_i,
    input  logic       sync_ready_i,
    output logic [2:0] mismatch_o,
    output logic       uncorr_o,
    output logic [2:0] repair_req_o,
    output logic       sync_valid_o,
    output logic [2:0] sync_tgt_o,
    output logic       start_o,
    output logic [1:0] start_idx_o
);
    rep_state_e state_q;
    logic [2:0] tgt_q;
    logic [2:0] diff_eff;
    logic [2:0] mism_q;
    logic       unc_q;
    logic [1:0] n_bad;
    logic       multi;

    // Count replicas that disagree, ignoring the one being rebuilt.
    always_comb begin
        diff_eff = diff_i & ~tgt_q;
        n_bad    = 2'(diff_eff[0]) + 2'(diff_eff[1]) + 2'(diff_eff[2]);
        multi    = (n_bad >= 2'd2);
        start_o  = (state_q == ST_IDLE) && (n_bad == 2'd1);
        start_idx_o = diff_eff[1] ? 2'd1 : (diff_eff[2] ? 2'd2 : 2'd0);
    end

    // Repair sequencer: idle, request repair, offer state, idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= 3'b000;
        end else begin
            case (state_q)
                ST_IDLE: if (start_o) begin
                    state_q <= ST_REPAIR;
                    tgt_q   <= diff_eff;
                end
                ST_REPAIR: if (repair_done_i) state_q <= ST_SYNC;
                ST_SYNC: if (sync_ready_i) begin
                    state_q <= ST_IDLE;
                    tgt_q   <= 3'b000;
                end
                default: begin
                    state_q <= ST_IDLE;
                    tgt_q   <= 3'b000;
                end
            endcase
        end
    end

    // Sticky flags; a fresh disagreement overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mism_q <= 3'b000;
            unc_q  <= 1'b0;
        end else begin
            mism_q <= (clear_i ? 3'b000 : mism_q) | diff_eff;
            unc_q  <= (clear_i ? 1'b0 : unc_q) | multi;
        end
    end

    assign mismatch_o   = mism_q;
    assign uncorr_o     = unc_q;
    assign repair_req_o = (state_q == ST_REPAIR) ? tgt_q : 3'b000;
    assign sync_valid_o = (state_q == ST_SYNC);
    assign sync_tgt_o   = (state_q == ST_SYNC) ? tgt_q : 3'b000;

    // R5
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(repair_req_o));
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repair_req_o != 3'b000 && !repair_done_i) |=> (repair_req_o == $past(repair_req_o)));
    // R6
    done_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (repair_req_o != 3'b000 && repair_done_i) |=> (sync_valid_o && sync_tgt_o == $past(repair_req_o)));
    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_valid_o && !sync_ready_i) |=> (sync_valid_o && $stable(sync_tgt_o)));
    // R3
    mism_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (($past(mismatch_o) & ~mismatch_o) == 3'b000));
    // R8
    unc_no_repair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(uncorr_o) && $past(repair_req_o == 3'b000 && !sync_valid_o)) |-> (repair_req_o == 3'b000));
endmodule

// File: rtl/tmr_voter_top.sv
// Triple-redundant position voter: injects host faults, votes bit by bit,
// registers the result, and drives repair and resync of a lone faulty replica.
// Assumes the three replicas run in lockstep on identical inputs.
module tmr_voter_top #(
    parameter int FIELD_W    = 10,
    parameter int NUM_FIELDS = 4,
    localparam int DATA_W    = FIELD_W * NUM_FIELDS,
    localparam int IDX_W     = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rep0_data,
    input  logic [DATA_W-1:0] rep1_data,
    input  logic [DATA_W-1:0] rep2_data,
    input  logic              inj_load,
    input  logic [1:0]        inj_sel,
    input  logic [IDX_W-1:0]  inj_field,
    input  logic [FIELD_W-1:0] inj_mask,
    input  logic              flag_clear,
    output logic [DATA_W-1:0] voted_data,
    output logic [2:0]        mismatch,
    output logic              uncorrectable,
    output logic [2:0]        repair_req,
    input  logic              repair_done,
    output logic              sync_valid,
    input  logic              sync_ready,
    output logic [2:0]        sync_tgt
);
    logic [2:0][DATA_W-1:0] raw_w;
    logic [2:0][DATA_W-1:0] eff_w;
    logic [DATA_W-1:0]      maj_w;
    logic [DATA_W-1:0]      voted_q;
    logic [2:0]             diff_w;
    logic                   start_w;
    logic [1:0]             start_idx_w;
    logic [1:0]             inj_tgt_w;

    assign raw_w[0] = rep0_data;
    assign raw_w[1] = rep1_data;
    assign raw_w[2] = rep2_data;

    tmr_fault_inject #(
        .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_inject (
        .clk(clk), .rst_n(rst_n),
        .load_i(inj_load), .sel_i(inj_sel), .field_i(inj_field), .mask_i(inj_mask),
        .clear_i(start_w), .clear_idx_i(start_idx_w),
        .raw_i(raw_w), .eff_o(eff_w), .tgt_o(inj_tgt_w)
    );

    tmr_majority #(
        .FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS), .DATA_W(DATA_W)
    ) u_vote (
        .rep_i(eff_w), .maj_o(maj_w), .diff_o(diff_w)
    );

    tmr_repair_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .diff_i(diff_w), .clear_i(flag_clear),
        .repair_done_i(repair_done), .sync_ready_i(sync_ready),
        .mismatch_o(mismatch), .uncorr_o(uncorrectable),
        .repair_req_o(repair_req), .sync_valid_o(sync_valid), .sync_tgt_o(sync_tgt),
        .start_o(start_w), .start_idx_o(start_idx_w)
    );

    // Single output register stage for the voted words.
    always_ff @(posedge clk) begin
        if (!rst_n) voted_q <= '0;
        else        voted_q <= maj_w;
    end

    assign voted_data = voted_q;

    // R7
    inj_cleared_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (inj_tgt_w != $past(start_idx_w) + 2'd1));
    // R5
    start_gives_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> $onehot(repair_req));
endmodule

// File: tb/tmr_voter_top_tb.sv
module tmr_voter_top_tb_top;
    localparam int FW = 10;
    localparam int NF = 4;
    localparam int DW = FW * NF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] r0, r1, r2;
    logic          inj_load;
    logic [1:0]    inj_sel;
    logic [1:0]    inj_field;
    logic [FW-1:0] inj_mask;
    logic          flag_clear;
    logic [DW-1:0] voted;
    logic [2:0]    mism;
    logic          unc;
    logic [2:0]    req;
    logic          done;
    logic          svalid;
    logic          sready;
    logic [2:0]    stgt;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_voter_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .rep0_data(r0), .rep1_data(r1), .rep2_data(r2),
        .inj_load(inj_load), .inj_sel(inj_sel), .inj_field(inj_field), .inj_mask(inj_mask),
        .flag_clear(flag_clear),
        .voted_data(voted), .mismatch(mism), .uncorrectable(unc),
        .repair_req(req), .repair_done(done),
        .sync_valid(svalid), .sync_ready(sready), .sync_tgt(stgt)
    );

    function automatic logic [DW-1:0] vote3(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    task automatic chk(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] base, bad, x;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; r0 = '0; r1 = '0; r2 = '0;
        inj_load = 0; inj_sel = 0; inj_field = 0; inj_mask = 0;
        flag_clear = 0; done = 0; sready = 0;
        repeat (3) tick();
        // R10 reset state
        chk("R10 voted", 64'(voted), 64'd0);
        chk("R10 flags", {60'd0, mism, unc}, 64'd0);
        chk("R10 handshake", {57'd0, req, svalid, stgt}, 64'd0);
        rst_n = 1'b1;

        // R1 clean random words pass straight through after one stage
        for (int i = 0; i < 20; i++) begin
            base = rnd_word();
            r0 = base; r1 = base; r2 = base;
            tick();
            chk("R1 clean vote", 64'(voted), 64'(base));
            chk("R1 no mismatch", 64'(mism), 64'd0);
        end

        // R2 R3 R5 R6 random single-replica corruption and full repair cycle
        for (int i = 0; i < 12; i++) begin
            int k;
            k = int'($urandom() % 3);
            base = rnd_word();
            x = rnd_word();
            if (x == '0) x = 1;
            bad = base ^ x;
            r0 = (k == 0) ? bad : base;
            r1 = (k == 1) ? bad : base;
            r2 = (k == 2) ? bad : base;
            tick();
            chk("R2 masked", 64'(voted), 64'(vote3(r0, r1, r2)));
            chk("R2 equals healthy", 64'(voted), 64'(base));
            chk("R3 mismatch bit", 64'(mism), 64'(3'b001 << k));
            chk("R5 repair request", 64'(req), 64'(3'b001 << k));
            chk("R8 no unc", 64'(unc), 64'd0);
            done = 1;
            tick();
            done = 0;
            chk("R6 sync valid", 64'(svalid), 64'd1);
            chk("R6 sync target", 64'(stgt), 64'(3'b001 << k));
            chk("R6 request dropped", 64'(req), 64'd0);
            tick();
            chk("R6 sync held", {62'd0, svalid, 1'b0} | 64'(stgt), {62'd0, 1'b1, 1'b0} | 64'(3'b001 << k));
            chk("R6 payload", 64'(voted), 64'(base));
            sready = 1;
            r0 = base; r1 = base; r2 = base;
            tick();
            sready = 0;
            chk("R6 back to idle", {60'd0, svalid, req}, 64'd0);
            flag_clear = 1;
            tick();
            flag_clear = 0;
            chk("R3 cleared", 64'(mism), 64'd0);
        end

        // R7 injection aimed at replica 1 is removed when its repair starts
        base = rnd_word();
        r0 = base; r1 = base; r2 = base;
        inj_load = 1; inj_sel = 2'd2; inj_field = 2'd0; inj_mask = 10'h0ff;
        tick();
        inj_load = 0;
        chk("R4 load edge unaffected", 64'(mism), 64'd0);
        tick();
        chk("R4 injected mismatch", 64'(mism), 64'b010);
        chk("R7 repair of injected", 64'(req), 64'b010);
        chk("R2 injected masked", 64'(voted), 64'(base));
        done = 1; tick(); done = 0;
        sready = 1; tick(); sready = 0;
        flag_clear = 1; tick(); flag_clear = 0;
        tick();
        chk("R7 injection gone", 64'(mism), 64'd0);
        chk("R7 no new repair", 64'(req), 64'd0);

        // R4 field 2 (bits 29:20) injection on replica 1 plus a real fault on replica 2 flips the vote
        base = rnd_word();
        x = DW'(10'h155) << 20;
        r0 = base; r1 = base; r2 = base;
        inj_load = 1; inj_sel = 2'd2; inj_field = 2'd2; inj_mask = 10'h155;
        tick();
        inj_load = 0;
        r2 = base ^ x;
        tick();
        chk("R4 field position in vote", 64'(voted), 64'(base ^ x));
        chk("R4 lone healthy flagged", 64'(mism), 64'b001);
        chk("R4 repair replica 0", 64'(req), 64'b001);
        r0 = base ^ x;
        done = 1; tick(); done = 0;
        sready = 1; tick(); sready = 0;
        flag_clear = 1; tick(); flag_clear = 0;
        chk("R4 rejoined", 64'(mism), 64'd0);
        inj_load = 1; inj_sel = 2'd0; tick(); inj_load = 0;
        r1 = base ^ x;
        tick();
        chk("R4 injection off", {61'd0, mism} | 64'(req), 64'd0);

        // R9 replica under repair is ignored while another goes bad
        base = rnd_word();
        r0 = base; r1 = base; r2 = base;
        tick();
        r0 = base ^ DW'(1);
        tick();
        chk("R9 repair 0 started", 64'(req), 64'b001);
        r1 = base ^ DW'(2);
        tick();
        chk("R9 other flagged", 64'(mism), 64'b011);
        chk("R9 no unc", 64'(unc), 64'd0);
        chk("R9 request kept", 64'(req), 64'b001);
        chk("R9 vote", 64'(voted), 64'(base));
        r0 = base; r1 = base;
        done = 1; tick(); done = 0;
        sready = 1; tick(); sready = 0;
        flag_clear = 1; tick(); flag_clear = 0;

        // R8 two replicas wrong from idle
        r0 = base ^ DW'(1); r1 = base ^ DW'(2); r2 = base;
        tick();
        chk("R8 unc set", 64'(unc), 64'd1);
        chk("R8 no repair", {61'd0, req} | {63'd0, svalid}, 64'd0);
        chk("R8 mismatch both", 64'(mism), 64'b011);
        chk("R8 vote", 64'(voted), 64'(base));
        r0 = base; r1 = base;
        tick();
        chk("R8 unc sticky", 64'(unc), 64'd1);
        chk("R8 still no repair", 64'(req), 64'd0);
        flag_clear = 1; tick(); flag_clear = 0;
        chk("R8 unc cleared", {60'd0, unc, mism}, 64'd0);

        summary();
        $finish;
    end
endmodule